// File: doc/BRIEF.md
# Detector Busy Combiner

This block keeps the live/busy picture of a set of readout detectors up to date on every bunch-clock tick and hands the trigger decision a single final busy vector. For every detector it merges three sources: the busy bit the detector drives itself, a short local busy that the block raises after a trigger, and a contamination busy. The local busy covers the gap before the detector's own busy arrives. The contamination busy starts when the upstream classifier flags that the current crossing would pollute any nearby event.

The block also watches triggered detectors for later pollution. A trigger opens a protection window for each detector it reaches. A contamination flag that arrives while that window is open sets a sticky "followed" bit. Software reads these bits and clears them by writing ones. Each detector has its own length for all three timed windows. Lengths are counted in ticks, and a length of zero turns the window off. The external, local, contamination, final and followed vectors are all visible at the ports at all times.

Every timed window is a small two-state machine. In state `W_IDLE` the window is closed. In state `W_RUN` it is open, and a down-counter holds the ticks that remain. The transitions are: *arm* (`W_IDLE`→`W_RUN` on a start with a nonzero length), *reload* (`W_RUN`→`W_RUN` on a start with a nonzero length, which reloads the full length), *tick* (`W_RUN`→`W_RUN`, counter above one, decrement), *expire* (`W_RUN`→`W_IDLE` when the counter is at one) and *kill* (any state →`W_IDLE` on a start with length zero).

Top module: `det_busy_combiner`

## Requirements
- R1: After reset the local, contamination and followed vectors are all zero, so the final busy vector equals the external busy input.
- R2: A detector whose `loc_en` bit is set and whose `trig_mask` bit is high in tick t shows local busy in ticks t+1 through t+`loc_len`. A detector whose `loc_en` bit is clear never starts local busy.
- R3: A new start while a window is open reloads that window to its full current length. It does not add to the time that remains.
- R4: A high `contam` in tick t puts every detector with a nonzero `cont_len` into contamination busy for ticks t+1 through t+`cont_len` of that detector.
- R5: Contamination busy reaches `busy_final` only for detectors whose `cont_en` bit is set. `sts_contam` shows it whatever the enable.
- R6: `busy_final[d]` is the OR of `ext_busy[d]`, the local busy and the enabled contamination busy, in the same tick and with no register on the external path.
- R7: A trigger on detector d in tick t opens its protection window for ticks t+1 through t+`prot_len`. A `contam` seen in an open window sets `sts_followed[d]` in the next tick. A `contam` in the trigger tick itself does not.
- R8: A followed bit stays set until a one is written to its `fol_clr` bit, which clears it in the next tick. If a set and a clear arrive in the same tick, the bit stays set.
- R9: `sts_ext` reflects `ext_busy` in the same tick.
- R10: A start with a length of zero closes any open window of that kind in the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_busy | input | NUM_DET | Busy bit driven by each detector |
| trig_mask | input | NUM_DET | Detectors triggered in this tick |
| contam | input | 1 | Contamination flag for this crossing |
| loc_en | input | NUM_DET | Per-detector enable for local post-trigger busy |
| loc_len | input | NUM_DET x LEN_W | Local busy length per detector, in ticks |
| cont_en | input | NUM_DET | Per-detector enable for contamination in the final state |
| cont_len | input | NUM_DET x LEN_W | Contamination busy length per detector |
| prot_len | input | NUM_DET x LEN_W | Protection window length per detector |
| fol_clr | input | NUM_DET | Write-one-to-clear strobe for followed bits |
| busy_final | output | NUM_DET | Combined busy vector for the trigger decision |
| sts_ext | output | NUM_DET | View of the external busy bits |
| sts_local | output | NUM_DET | Local post-trigger busy vector |
| sts_contam | output | NUM_DET | Contamination busy vector, before the enable |
| sts_followed | output | NUM_DET | Sticky followed-event bits |

## Verification
The bench builds the block with its default parameters: 16 detectors and 4-bit lengths. With windows of at most 15 ticks, random runs of a few thousand ticks pass through arm, reload, expiry and kill on every detector many times. A cycle model in the bench tracks one down-counter per window. Directed sequences cover reload in mid-window, a zero length that closes a window, a contamination flag in the same tick as a trigger, a set and a clear in the same tick, and a flip of the enables.

// File: rtl/det_busy_pkg.sv
package det_busy_pkg;

    // State of one timed busy or protection window
    typedef enum logic {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } win_state_e;

endpackage

// File: rtl/dbc_window.sv
module dbc_window
    import det_busy_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             active
);

    localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0] ZERO = '0;

    win_state_e       st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= W_IDLE;
            cnt_q <= ZERO;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: arm, reload, tick, expire, kill
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (start) begin
            if (len == ZERO) begin
                st_d  = W_IDLE;
                cnt_d = ZERO;
            end else begin
                st_d  = W_RUN;
                cnt_d = len;
            end
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    st_d  = W_IDLE;
                    cnt_d = ZERO;
                end
                W_RUN: begin
                    if (cnt_q <= ONE) begin
                        st_d  = W_IDLE;
                        cnt_d = ZERO;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    st_d  = W_IDLE;
                    cnt_d = ZERO;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        active = (st_q == W_RUN);
    end

endmodule

// File: rtl/dbc_det_slice.sv
module dbc_det_slice #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             contam,
    input  logic             loc_en,
    input  logic [LEN_W-1:0] loc_len,
    input  logic [LEN_W-1:0] cont_len,
    input  logic [LEN_W-1:0] prot_len,
    output logic             loc_act,
    output logic             cont_act,
    output logic             prot_act
);

    logic loc_start;

    always_comb begin
        loc_start = trig & loc_en;
    end

    dbc_window #(.LEN_W(LEN_W)) u_loc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (loc_start),
        .len    (loc_len),
        .active (loc_act)
    );

    dbc_window #(.LEN_W(LEN_W)) u_cont (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (contam),
        .len    (cont_len),
        .active (cont_act)
    );

    dbc_window #(.LEN_W(LEN_W)) u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (trig),
        .len    (prot_len),
        .active (prot_act)
    );

endmodule

// File: rtl/dbc_followed.sv
module dbc_followed #(
    parameter int NUM_DET = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               contam,
    input  logic [NUM_DET-1:0] prot_act,
    input  logic [NUM_DET-1:0] clr,
    output logic [NUM_DET-1:0] flags
);

    logic [NUM_DET-1:0] flags_q, flags_d, hit;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // set has priority over the clear strobe
    always_comb begin
        hit     = prot_act & {NUM_DET{contam}};
        flags_d = (flags_q & ~clr) | hit;
    end

    always_comb begin
        flags = flags_q;
    end

endmodule

// File: rtl/det_busy_combiner.sv
module det_busy_combiner #(
    parameter int NUM_DET = 16,
    parameter int LEN_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_DET-1:0]            ext_busy,
    input  logic [NUM_DET-1:0]            trig_mask,
    input  logic                          contam,
    input  logic [NUM_DET-1:0]            loc_en,
    input  logic [NUM_DET-1:0][LEN_W-1:0] loc_len,
    input  logic [NUM_DET-1:0]            cont_en,
    input  logic [NUM_DET-1:0][LEN_W-1:0] cont_len,
    input  logic [NUM_DET-1:0][LEN_W-1:0] prot_len,
    input  logic [NUM_DET-1:0]            fol_clr,
    output logic [NUM_DET-1:0]            busy_final,
    output logic [NUM_DET-1:0]            sts_ext,
    output logic [NUM_DET-1:0]            sts_local,
    output logic [NUM_DET-1:0]            sts_contam,
    output logic [NUM_DET-1:0]            sts_followed
);

    logic [NUM_DET-1:0] loc_act, cont_act, prot_act;

    for (genvar d = 0; d < NUM_DET; d++) begin : g_det
        dbc_det_slice #(.LEN_W(LEN_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig     (trig_mask[d]),
            .contam   (contam),
            .loc_en   (loc_en[d]),
            .loc_len  (loc_len[d]),
            .cont_len (cont_len[d]),
            .prot_len (prot_len[d]),
            .loc_act  (loc_act[d]),
            .cont_act (cont_act[d]),
            .prot_act (prot_act[d])
        );
    end

    dbc_followed #(.NUM_DET(NUM_DET)) u_fol (
        .clk      (clk),
        .rst_n    (rst_n),
        .contam   (contam),
        .prot_act (prot_act),
        .clr      (fol_clr),
        .flags    (sts_followed)
    );

    always_comb begin
        sts_ext    = ext_busy;
        sts_local  = loc_act;
        sts_contam = cont_act;
        busy_final = ext_busy | loc_act | (cont_act & cont_en);
    end

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int NUM_DET = 16,
    parameter int LEN_W   = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_DET-1:0]            ext_busy,
    input logic [NUM_DET-1:0]            trig_mask,
    input logic                          contam,
    input logic [NUM_DET-1:0]            loc_en,
    input logic [NUM_DET-1:0][LEN_W-1:0] loc_len,
    input logic [NUM_DET-1:0][LEN_W-1:0] cont_len,
    input logic [NUM_DET-1:0]            fol_clr,
    input logic [NUM_DET-1:0]            busy_final,
    input logic [NUM_DET-1:0]            sts_local,
    input logic [NUM_DET-1:0]            sts_contam,
    input logic [NUM_DET-1:0]            sts_followed
);

    for (genvar d = 0; d < NUM_DET; d++) begin : g_chk
        // R2: enabled trigger with a nonzero length opens local busy
        p_local_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_mask[d] && loc_en[d] && loc_len[d] != '0) |=> sts_local[d]);

        // R2: local busy never appears without an enabled trigger
        p_local_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!sts_local[d] && !(trig_mask[d] && loc_en[d])) |=> !sts_local[d]);

        // R4: contamination flag opens contamination busy
        p_contam_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (contam && cont_len[d] != '0) |=> sts_contam[d]);

        // R6: external busy always reaches the final vector
        p_ext_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ext_busy[d] |-> busy_final[d]);

        // R7: a followed bit rises only after a contamination flag
        p_fol_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_followed[d]) |-> $past(contam));

        // R8: a followed bit holds unless cleared
        p_fol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_followed[d] && !fol_clr[d]) |=> sts_followed[d]);
    end

endmodule

bind det_busy_combiner dbc_checker #(.NUM_DET(NUM_DET), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/det_busy_combiner_bench.sv
`timescale 1ns/1ps
module det_busy_combiner_bench;

    localparam int N  = 16;
    localparam int LW = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         ext_busy = '0, trig_mask = '0, loc_en = '0, cont_en = '0, fol_clr = '0;
    logic                 contam = 1'b0;
    logic [N-1:0][LW-1:0] loc_len = '0, cont_len = '0, prot_len = '0;
    logic [N-1:0]         busy_final, sts_ext, sts_local, sts_contam, sts_followed;

    int tests = 0;
    int fails = 0;
    int loc_c[N], con_c[N], pro_c[N];
    logic [N-1:0] fol_m = '0;

    always #2 clk = ~clk;

    det_busy_combiner #(.NUM_DET(N), .LEN_W(LW)) u_det_busy_combiner (
        .clk(clk), .rst_n(rst_n), .ext_busy(ext_busy), .trig_mask(trig_mask),
        .contam(contam), .loc_en(loc_en), .loc_len(loc_len), .cont_en(cont_en),
        .cont_len(cont_len), .prot_len(prot_len), .fol_clr(fol_clr),
        .busy_final(busy_final), .sts_ext(sts_ext), .sts_local(sts_local),
        .sts_contam(sts_contam), .sts_followed(sts_followed)
    );

    function automatic int upd(logic s, int len, int c);
        if (s) return len;
        if (c > 0) return c - 1;
        return c;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negedge with inputs already applied
    task automatic step(string tag);
        logic [N-1:0] e_loc, e_con;
        #1;
        for (int d = 0; d < N; d++) begin
            e_loc[d] = (loc_c[d] > 0);
            e_con[d] = (con_c[d] > 0);
        end
        chk({tag, " R2 local"}, sts_local, e_loc);
        chk({tag, " R4 contam"}, sts_contam, e_con);
        chk({tag, " R6 R5 final"}, busy_final, ext_busy | e_loc | (e_con & cont_en));
        chk({tag, " R7 R8 followed"}, sts_followed, fol_m);
        chk({tag, " R9 ext"}, sts_ext, ext_busy);
        @(posedge clk);
        for (int d = 0; d < N; d++) begin
            fol_m[d] = (fol_m[d] & ~fol_clr[d]) | (contam & (pro_c[d] > 0));
            loc_c[d] = upd(trig_mask[d] & loc_en[d], int'(loc_len[d]), loc_c[d]);
            con_c[d] = upd(contam, int'(cont_len[d]), con_c[d]);
            pro_c[d] = upd(trig_mask[d], int'(prot_len[d]), pro_c[d]);
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        trig_mask = '0; contam = 1'b0; fol_clr = '0;
    endtask

    initial begin : watchdog
        #800000;
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2718));
        for (int d = 0; d < N; d++) begin
            loc_c[d] = 0; con_c[d] = 0; pro_c[d] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with some external busy applied
        ext_busy = 16'h00F0;
        step("R1");

        // R2 / R3 / R10 on detector 0
        ext_busy = '0;
        for (int d = 0; d < N; d++) begin
            loc_len[d] = LW'(3); cont_len[d] = LW'(2); prot_len[d] = LW'(4);
        end
        loc_en = 16'h0001;
        trig_mask = 16'h0003;          // det1 triggered but local disabled (R2)
        step("R2 start");
        idle_inputs();
        step("R2 run");
        trig_mask = 16'h0001;          // reload mid-window (R3)
        step("R3 reload");
        idle_inputs();
        repeat (4) step("R3 tail");
        trig_mask = 16'h0001;
        step("R10 arm");
        loc_len[0] = '0;               // zero length kills the window (R10)
        step("R10 kill");
        idle_inputs();
        loc_len[0] = LW'(3);
        repeat (2) step("R10 after");

        // R7: followed set inside window, not on trigger tick
        trig_mask = 16'h0002; contam = 1'b1;   // same tick: no followed for det1
        step("R7 same tick");
        trig_mask = '0; contam = 1'b0;
        step("R7 open");
        contam = 1'b1;
        step("R7 hit");
        contam = 1'b0;
        step("R7 set");
        // R8: set and clear together keep it set, then a lone clear
        trig_mask = 16'h0002;
        step("R8 rearm");
        trig_mask = '0; contam = 1'b1; fol_clr = 16'h0002;
        step("R8 set+clr");
        idle_inputs();
        step("R8 held");
        fol_clr = 16'h0002;
        step("R8 clr");
        idle_inputs();
        step("R8 cleared");

        // R5: contamination gated into final by enable
        cont_en = 16'h00FF; contam = 1'b1;
        step("R5 arm");
        contam = 1'b0;
        repeat (3) step("R5 run");

        // random phases
        for (int ph = 0; ph < 8; ph++) begin
            for (int d = 0; d < N; d++) begin
                loc_len[d]  = LW'($urandom_range(0, 15));
                cont_len[d] = LW'($urandom_range(0, 15));
                prot_len[d] = LW'($urandom_range(0, 15));
            end
            loc_en  = N'($urandom);
            cont_en = N'($urandom);
            for (int i = 0; i < 500; i++) begin
                ext_busy  = N'($urandom) & N'($urandom);
                trig_mask = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
                contam    = ($urandom_range(0, 7) == 0);
                fol_clr   = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
                step("rand");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule